// File: doc/BRIEF.md
# Saturating Subtract Execution Unit

This block is the execution slice of a 32-bit processor core that carries out the subtract-with-saturation instructions. Each cycle it can accept one instruction word with a valid strobe. A side input says whether the word is a 16-bit or a 32-bit encoding. The unit decodes the word and reads two operands from its 16 x 32-bit data register file. It subtracts the second operand from the first and clamps the difference to the signed or unsigned 32-bit range. On the next clock edge it writes the result back to the register file, then updates an overflow flag and a sticky overflow flag.

Three encodings are accepted. The 32-bit form selects signed or unsigned arithmetic and names a separate destination. The 16-bit short form is always signed and overwrites its first source. Any other word raises a one-cycle illegal-instruction pulse and changes no state. A separate write port lets neighbouring logic load the register file. The result of every executed subtract is also presented on a registered result port, which is the only view of the register contents at the block's edge.

Top module: `sat_sub_unit`

## Requirements
- R1: Signed mode: when the exact difference a - b (both taken as two's-complement) is above 0x7FFFFFFF the result is 0x7FFFFFFF; when it is below -2^31 the result is 0x80000000.
- R2: Unsigned mode: when a - b is negative the result is 0x00000000; a difference up to 0xFFFFFFFF is written exactly.
- R3: When no clamping is needed, the result equals the first source register minus the second source register.
- R4: On every executed instruction, ovf_flag becomes 1 if clamping occurred and 0 otherwise. It holds its value on cycles with no executed instruction.
- R5: sticky_flag becomes 1 on an executed instruction that overflows. Otherwise it keeps its value, unless it is cleared.
- R6: A pulse on sticky_clr clears sticky_flag on the next edge. If an overflow occurs on the same edge, the set wins.
- R7: 32-bit form: bits [7:0] = 0x0B, bits [11:8] = source a, bits [15:12] = source b, bits [27:20] = 0x0A (signed) or 0x0B (unsigned), bits [31:28] = destination. Bits [19:16] are ignored.
- R8: 16-bit form (instr_is_short = 1): bits [7:0] = 0x62, bits [11:8] = source a and destination, bits [15:12] = source b. It is always signed, and bits [31:16] of the word are ignored.
- R9: A valid word that matches none of the encodings pulses illegal_instr for one cycle one edge later. No register, result or flag changes.
- R10: Write-back, res_valid and the flag update take effect on the first clock edge after the cycle in which instr_valid is high. res_valid is a one-cycle pulse per executed instruction.
- R11: A synchronous active-low reset clears all registers, both flags, res_valid and illegal_instr.
- R12: The external write port stores ext_wdata into ext_waddr on the clock edge. If the unit writes the same register on the same edge, the unit's result is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_is_short | input | 1 | 1: word holds a 16-bit encoding in bits [15:0] |
| instr_word | input | 32 | Instruction word |
| sticky_clr | input | 1 | Clears the sticky overflow flag |
| ext_we | input | 1 | External register write enable |
| ext_waddr | input | 4 | External write register index |
| ext_wdata | input | 32 | External write data |
| res_valid | output | 1 | Pulse: a result was written back |
| res_addr | output | 4 | Register written by the last executed instruction |
| res_data | output | 32 | Value written by the last executed instruction |
| ovf_flag | output | 1 | Overflow flag of the last executed instruction |
| sticky_flag | output | 1 | Sticky overflow flag |
| illegal_instr | output | 1 | Pulse: the last valid word was not decodable |

## Verification
The assertions assume that instr_valid, instr_is_short, instr_word and sticky_clr carry known values on every clock after reset. They also assume instr_valid is low while reset is asserted, so no instruction straddles reset release. The bench changes every input only on the falling clock edge. It holds instr_valid and sticky_clr low through reset and clears the instruction word whenever no instruction is issued.

// File: rtl/sat_sub_pkg.sv
// Package: encoding constants and the decoded-instruction type shared by
// the saturating subtract unit. Assumes the 4-bit register index fields of
// the instruction set.
package sat_sub_pkg;
    localparam int INSTR_W = 32;
    localparam int RF_AW   = 4;
    localparam int OPC_W   = 8;

    localparam logic [OPC_W-1:0] OPC_LONG     = 8'h0B;
    localparam logic [OPC_W-1:0] OPC_SHORT    = 8'h62;
    localparam logic [OPC_W-1:0] SUB_SIGNED   = 8'h0A;
    localparam logic [OPC_W-1:0] SUB_UNSIGNED = 8'h0B;

    typedef struct packed {
        logic             legal;
        logic             is_signed;
        logic [RF_AW-1:0] src_a;
        logic [RF_AW-1:0] src_b;
        logic [RF_AW-1:0] dst;
    } dec_t;
endpackage

// File: rtl/sat_sub_decode.sv
// Decoder: maps a 16-bit or 32-bit instruction word to operand indices,
// destination, arithmetic mode and a legality bit. Purely combinational.
// Assumes the caller qualifies the result with its own valid strobe.
module sat_sub_decode
    import sat_sub_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    input  logic               is_short,
    output dec_t               dec
);
    logic [OPC_W-1:0] prim_opc;
    logic [OPC_W-1:0] sec_opc;
    logic [3:0]       unused_rsvd;

    assign prim_opc    = word[7:0];
    assign sec_opc     = word[27:20];
    assign unused_rsvd = word[19:16];

    // Field extraction and opcode match for both encoding lengths.
    always_comb begin
        dec.src_a     = word[11:8];
        dec.src_b     = word[15:12];
        dec.legal     = 1'b0;
        dec.is_signed = 1'b1;
        dec.dst       = word[11:8];
        if (is_short) begin
            dec.legal = (prim_opc == OPC_SHORT);
        end else begin
            dec.dst       = word[31:28];
            dec.is_signed = (sec_opc == SUB_SIGNED);
            dec.legal     = (prim_opc == OPC_LONG) &&
                            ((sec_opc == SUB_SIGNED) || (sec_opc == SUB_UNSIGNED));
        end
    end
endmodule

// File: rtl/sat_sub_alu.sv
// Saturating subtractor: forms a - b one bit wider than the operands
// (sign- or zero-extended by mode) and clamps to the operand range.
// Combinational; assumes W >= 2.
module sat_sub_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         is_signed,
    output logic [W-1:0] result,
    output logic         ovf
);
    localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] U_MIN = '0;

    logic [W:0]   ext_a;
    logic [W:0]   ext_b;
    logic [W:0]   diff;
    logic [W-1:0] clamp;

    // Extend operands by mode and subtract.
    always_comb begin
        ext_a = is_signed ? {op_a[W-1], op_a} : {1'b0, op_a};
        ext_b = is_signed ? {op_b[W-1], op_b} : {1'b0, op_b};
        diff  = ext_a - ext_b;
    end

    // Detect out-of-range differences and pick the clamp value.
    always_comb begin
        if (is_signed) begin
            ovf   = diff[W] ^ diff[W-1];
            clamp = diff[W] ? S_MIN : S_MAX;
        end else begin
            ovf   = diff[W];
            clamp = U_MIN;
        end
        result = ovf ? clamp : diff[W-1:0];
    end
endmodule

// File: rtl/sat_sub_regfile.sv
// Register file: N entries of W bits, two asynchronous read ports and two
// write ports. Port 0 (execution write-back) wins over port 1 (external)
// on an address clash. Synchronous active-low reset clears every entry.
module sat_sub_regfile #(
    parameter int W = 32,
    parameter int N = 16,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_addr,
    output logic [W-1:0]  rd_a_data,
    input  logic [AW-1:0] rd_b_addr,
    output logic [W-1:0]  rd_b_data,
    input  logic          wr0_en,
    input  logic [AW-1:0] wr0_addr,
    input  logic [W-1:0]  wr0_data,
    input  logic          wr1_en,
    input  logic [AW-1:0] wr1_addr,
    input  logic [W-1:0]  wr1_data
);
    logic [W-1:0] ent_q [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic [W-1:0] q;
        logic         hit0;
        logic         hit1;

        assign hit0     = wr0_en && (wr0_addr == AW'(i));
        assign hit1     = wr1_en && (wr1_addr == AW'(i));
        assign ent_q[i] = q;

        // Store one entry, execution port first.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (hit0) begin
                q <= wr0_data;
            end else if (hit1) begin
                q <= wr1_data;
            end
        end
    end

    assign rd_a_data = ent_q[rd_a_addr];
    assign rd_b_data = ent_q[rd_b_addr];
endmodule

// File: rtl/sat_sub_flags.sv
// Status bits: overflow flag rewritten on each executed instruction, sticky
// overflow flag set on overflow and cleared by request (set wins).
module sat_sub_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic ovf_in,
    input  logic sticky_clr,
    output logic ovf_q,
    output logic sticky_q
);
    // Overflow flag follows each executed instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (upd) begin
            ovf_q <= ovf_in;
        end
    end

    // Sticky flag: set on overflow, else clear on request, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= 1'b0;
        end else if (upd && ovf_in) begin
            sticky_q <= 1'b1;
        end else if (sticky_clr) begin
            sticky_q <= 1'b0;
        end
    end
endmodule

// File: rtl/sat_sub_unit.sv
// Top: saturating subtract execution slice. Decodes one instruction per
// cycle, reads two registers, subtracts with clamping and commits result
// and flags on the next edge. Assumes instr_valid is low during reset.
module sat_sub_unit
    import sat_sub_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AW    = RF_AW,
    localparam int REG_N = 1 << AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic               instr_is_short,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic               sticky_clr,
    input  logic               ext_we,
    input  logic [AW-1:0]      ext_waddr,
    input  logic [DATA_W-1:0]  ext_wdata,
    output logic               res_valid,
    output logic [AW-1:0]      res_addr,
    output logic [DATA_W-1:0]  res_data,
    output logic               ovf_flag,
    output logic               sticky_flag,
    output logic               illegal_instr
);
    dec_t              dec;
    logic              exec;
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] diff_sat;
    logic              diff_ovf;

    sat_sub_decode u_dec (
        .word     (instr_word),
        .is_short (instr_is_short),
        .dec      (dec)
    );

    assign exec = instr_valid && dec.legal;

    sat_sub_regfile #(.W(DATA_W), .N(REG_N)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_addr (dec.src_a),
        .rd_a_data (opa),
        .rd_b_addr (dec.src_b),
        .rd_b_data (opb),
        .wr0_en    (exec),
        .wr0_addr  (dec.dst),
        .wr0_data  (diff_sat),
        .wr1_en    (ext_we),
        .wr1_addr  (ext_waddr),
        .wr1_data  (ext_wdata)
    );

    sat_sub_alu #(.W(DATA_W)) u_alu (
        .op_a      (opa),
        .op_b      (opb),
        .is_signed (dec.is_signed),
        .result    (diff_sat),
        .ovf       (diff_ovf)
    );

    sat_sub_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (exec),
        .ovf_in     (diff_ovf),
        .sticky_clr (sticky_clr),
        .ovf_q      (ovf_flag),
        .sticky_q   (sticky_flag)
    );

    // Result port and strobes, registered with the write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid     <= 1'b0;
            illegal_instr <= 1'b0;
            res_addr      <= '0;
            res_data      <= '0;
        end else begin
            res_valid     <= exec;
            illegal_instr <= instr_valid && !dec.legal;
            if (exec) begin
                res_addr <= dec.dst;
                res_data <= diff_sat;
            end
        end
    end
endmodule

// File: rtl/sat_sub_unit_chk.sv
// Checker: temporal properties of the saturating subtract unit, observed at
// its ports. Assumes inputs are known after reset and idle during reset.
module sat_sub_unit_chk #(
    parameter int DATA_W = 32,
    parameter int AW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic              instr_is_short,
    input logic [31:0]       instr_word,
    input logic              sticky_clr,
    input logic              res_valid,
    input logic [AW-1:0]     res_addr,
    input logic [DATA_W-1:0] res_data,
    input logic              ovf_flag,
    input logic              sticky_flag,
    input logic              illegal_instr
);
    localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    AST_WB_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(instr_valid)); // R10
    AST_ILLEGAL_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_instr |-> !res_valid); // R9
    AST_ILLEGAL_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_instr |-> $past(instr_valid)); // R9
    AST_OVF_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && ovf_flag) |-> (res_data == S_MAX || res_data == S_MIN || res_data == '0)); // R1
    AST_STICKY_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && ovf_flag) |-> sticky_flag); // R5
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !$past(sticky_clr)) |-> $stable(sticky_flag)); // R5
    AST_V_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(ovf_flag)); // R4
    AST_STICKY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sticky_clr) && !res_valid) |-> !sticky_flag); // R6
    AST_SHORT_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && instr_valid && instr_is_short && instr_word[7:0] == 8'h62)
        |-> (res_valid && res_addr == $past(instr_word[11:8]))); // R8
endmodule

bind sat_sub_unit sat_sub_unit_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .instr_valid    (instr_valid),
    .instr_is_short (instr_is_short),
    .instr_word     (instr_word),
    .sticky_clr     (sticky_clr),
    .res_valid      (res_valid),
    .res_addr       (res_addr),
    .res_data       (res_data),
    .ovf_flag       (ovf_flag),
    .sticky_flag    (sticky_flag),
    .illegal_instr  (illegal_instr)
);

// File: tb/sat_sub_unit_bench.sv
// Bench: behavioural reference model compared on every falling edge, plus
// directed checks with hand-computed values.
module sat_sub_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic        instr_is_short = 1'b0;
    logic [31:0] instr_word = '0;
    logic        sticky_clr = 1'b0;
    logic        ext_we = 1'b0;
    logic [3:0]  ext_waddr = '0;
    logic [31:0] ext_wdata = '0;
    logic        res_valid;
    logic [3:0]  res_addr;
    logic [31:0] res_data;
    logic        ovf_flag;
    logic        sticky_flag;
    logic        illegal_instr;

    always #4 clk = ~clk;

    sat_sub_unit u_sat_sub_unit (.*);

    int n_chk = 0;
    int n_err = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model state.
    logic [31:0] m_rf [16];
    bit          m_rv, m_v, m_sv, m_ill;
    logic [3:0]  m_ra;
    logic [31:0] m_rd;

    always @(posedge clk) begin : model
        bit          legal, sgn, ov;
        logic [3:0]  dst;
        logic [31:0] res;
        longint      va, vb, r;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_rf[i] = '0;
            m_rv = 0; m_v = 0; m_sv = 0; m_ill = 0; m_ra = '0; m_rd = '0;
        end else begin
            legal = 0; sgn = 1; dst = instr_word[11:8]; ov = 0; res = '0;
            if (instr_is_short) begin
                legal = (instr_word[7:0] == 8'h62);
            end else begin
                legal = (instr_word[7:0] == 8'h0B) &&
                        (instr_word[27:20] == 8'h0A || instr_word[27:20] == 8'h0B);
                sgn   = (instr_word[27:20] == 8'h0A);
                dst   = instr_word[31:28];
            end
            if (instr_valid && legal) begin
                va = sgn ? longint'($signed(m_rf[instr_word[11:8]])) : longint'(m_rf[instr_word[11:8]]);
                vb = sgn ? longint'($signed(m_rf[instr_word[15:12]])) : longint'(m_rf[instr_word[15:12]]);
                r  = va - vb;
                if (sgn && r > 64'sd2147483647)       begin ov = 1; res = 32'h7FFF_FFFF; end
                else if (sgn && r < -64'sd2147483648) begin ov = 1; res = 32'h8000_0000; end
                else if (!sgn && r < 0)               begin ov = 1; res = 32'h0; end
                else                                        res = r[31:0];
            end
            if (ext_we) m_rf[ext_waddr] = ext_wdata;
            m_rv  = instr_valid && legal;
            m_ill = instr_valid && !legal;
            if (m_rv) begin
                m_rf[dst] = res; m_ra = dst; m_rd = res; m_v = ov;
            end
            if (m_rv && ov) m_sv = 1;
            else if (sticky_clr) m_sv = 0;
        end
    end

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R10 res_valid", 32'(res_valid), 32'(m_rv));
            chk("R7 res_addr", 32'(res_addr), 32'(m_ra));
            chk("R3 res_data", res_data, m_rd);
            chk("R4 ovf_flag", 32'(ovf_flag), 32'(m_v));
            chk("R5 sticky_flag", 32'(sticky_flag), 32'(m_sv));
            chk("R9 illegal_instr", 32'(illegal_instr), 32'(m_ill));
        end
    end

    function automatic logic [31:0] lw(input logic [3:0] c, input logic [7:0] sec,
                                       input logic [3:0] b, input logic [3:0] a);
        return {c, sec, 4'h0, b, a, 8'h0B};
    endfunction

    task automatic run(input logic [31:0] w, input bit sh = 0, input bit clr = 0,
                       input bit xwe = 0, input logic [3:0] xa = 0, input logic [31:0] xd = 0);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = w; instr_is_short = sh; sticky_clr = clr;
        ext_we = xwe; ext_waddr = xa; ext_wdata = xd;
        @(negedge clk);
        instr_valid = 1'b0; instr_word = '0; instr_is_short = 1'b0; sticky_clr = 1'b0;
        ext_we = 1'b0;
    endtask

    task automatic load(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        ext_we = 1'b1; ext_waddr = a; ext_wdata = d;
        @(negedge clk);
        ext_we = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        logic sv_before;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 res_valid", 32'(res_valid), 0);
        chk("R11 ovf", 32'(ovf_flag), 0);
        chk("R11 sticky", 32'(sticky_flag), 0);
        chk("R11 illegal", 32'(illegal_instr), 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        run(lw(4'd15, 8'h0B, 4'd6, 4'd8));
        chk("R11 register cleared", res_data, 32'h0);

        load(4'd1, 32'h7FFF_FFFF);
        load(4'd2, 32'hFFFF_FFFF);
        load(4'd3, 32'h8000_0000);
        load(4'd4, 32'd5);
        load(4'd5, 32'd3);

        run(lw(4'd7, 8'h0A, 4'd2, 4'd1));
        chk("R1 signed high clamp", res_data, 32'h7FFF_FFFF);
        chk("R4 V set", 32'(ovf_flag), 1);
        chk("R5 SV set", 32'(sticky_flag), 1);
        chk("R7 dest field", 32'(res_addr), 7);
        chk("R10 write-back pulse", 32'(res_valid), 1);

        run(lw(4'd8, 8'h0A, 4'd4, 4'd3));
        chk("R1 signed low clamp", res_data, 32'h8000_0000);

        run(lw(4'd9, 8'h0A, 4'd5, 4'd4));
        chk("R3 plain difference", res_data, 32'd2);
        chk("R4 V cleared", 32'(ovf_flag), 0);
        chk("R5 SV holds", 32'(sticky_flag), 1);
        @(negedge clk);
        chk("R10 pulse ends", 32'(res_valid), 0);

        @(negedge clk); sticky_clr = 1'b1;
        @(negedge clk); sticky_clr = 1'b0;
        chk("R6 SV cleared", 32'(sticky_flag), 0);
        chk("R4 V held", 32'(ovf_flag), 0);

        run(lw(4'd10, 8'h0B, 4'd4, 4'd5));
        chk("R2 unsigned low clamp", res_data, 32'h0);
        chk("R2 V set", 32'(ovf_flag), 1);

        run(lw(4'd11, 8'h0B, 4'd6, 4'd2));
        chk("R2 unsigned full range", res_data, 32'hFFFF_FFFF);
        chk("R2 V clear", 32'(ovf_flag), 0);

        run({16'hBEEF, 4'd5, 4'd4, 8'h62}, 1'b1);
        chk("R8 short dest is a", 32'(res_addr), 4);
        chk("R8 short result", res_data, 32'd2);
        run(lw(4'd12, 8'h0A, 4'd6, 4'd4));
        chk("R8 short write-back", res_data, 32'd2);

        run({16'h1234, 4'd4, 4'd3, 8'h62}, 1'b1);
        chk("R8 short is signed", res_data, 32'h8000_0000);
        chk("R8 short V", 32'(ovf_flag), 1);

        sv_before = sticky_flag;
        run(lw(4'd13, 8'h0C, 4'd2, 4'd1));
        chk("R9 bad secondary opcode", 32'(illegal_instr), 1);
        chk("R9 no write-back", 32'(res_valid), 0);
        chk("R9 V unchanged", 32'(ovf_flag), 1);
        chk("R9 SV unchanged", 32'(sticky_flag), 32'(sv_before));
        run({4'd13, 8'h0A, 4'h0, 4'd2, 4'd1, 8'h0C});
        chk("R9 bad primary opcode", 32'(illegal_instr), 1);
        run(lw(4'd13, 8'h0A, 4'd2, 4'd1), 1'b1);
        chk("R9 long opcode in short slot", 32'(illegal_instr), 1);
        run(lw(4'd14, 8'h0B, 4'd6, 4'd13));
        chk("R9 register untouched", res_data, 32'h0);

        run(lw(4'd14, 8'h0A, 4'd4, 4'd5) | 32'h000F_0000);
        chk("R7 reserved bits ignored", 32'(res_valid), 1);
        chk("R7 reserved bits result", res_data, 32'd1);

        run(lw(4'd5, 8'h0B, 4'd6, 4'd1), 1'b0, 1'b0, 1'b1, 4'd5, 32'h0000_1234);
        run(lw(4'd14, 8'h0B, 4'd6, 4'd5));
        chk("R12 unit write wins", res_data, 32'h7FFF_FFFF);
        run(lw(4'd14, 8'h0B, 4'd6, 4'd2));
        chk("R12 external write stored", res_data, 32'hFFFF_FFFF);

        run(lw(4'd14, 8'h0A, 4'd2, 4'd1), 1'b0, 1'b1);
        chk("R6 set wins over clear", 32'(sticky_flag), 1);
        run(lw(4'd14, 8'h0A, 4'd6, 4'd4), 1'b0, 1'b1);
        chk("R6 clear with legal op", 32'(sticky_flag), 0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule